// File: doc/BRIEF.md
# Partial-Write Integer Register File

This block holds the eight 32-bit general integer registers of a processor datapath. Every register can be accessed as a full 32-bit word or through a 16-bit view of its low half. Four of the registers, the accumulator-class group, additionally offer two 8-bit views: the low byte and the byte just above it.

There is one write port and two read ports. Each port carries a register index and a 2-bit view selector. A narrow write merges the new field into the register's existing contents, so every bit outside the view is kept. A narrow read returns the chosen field zero-extended to 32 bits. If a byte view is requested on a register that has no byte views, the port raises an illegal-access flag: a write is then dropped, and a read returns zero.

Reads are combinational from the stored state. A read that hits the register being written in the same cycle therefore sees the old contents, and the new value appears from the next cycle onward.

Top module: `gpr_file`

## Requirements
- R1: While the active-low reset `rst_n` is low, and after it is released, every register reads as zero until it is written.
- R2: A write with view code 00 (word) replaces all 32 bits of the register selected by index.
- R3: A write with view code 01 (half) replaces bits 15:0 and leaves bits 31:16 unchanged.
- R4: A write with view code 10 (low byte) to index 0..3 replaces bits 7:0 and leaves bits 31:8 unchanged.
- R5: A write with view code 11 (high byte) to index 0..3 replaces bits 15:8 and leaves bits 31:16 and 7:0 unchanged.
- R6: A write with view code 10 or 11 to index 4..7 drives `wr_illegal` high in that cycle and leaves every register unchanged. Otherwise `wr_illegal` is low.
- R7: A read returns the whole register for code 00. For code 01 it returns bits 15:0, for code 10 bits 7:0, and for code 11 bits 15:8 placed in bits 7:0. All unused upper bits are zero.
- R8: A read with code 10 or 11 on index 4..7 drives that port's illegal flag high and returns zero.
- R9: A read of the register being written in the same cycle returns the value from before the write. The written value is returned from the following cycle.
- R10: The two read ports decode their index and view independently and can read different registers at the same time.
- R11: With `wr_en` low, no register changes, whatever the write index, view and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index (0 acc, 1 counter, 2 data, 3 base, 4 stack ptr, 5 base ptr, 6 src idx, 7 dst idx) |
| wr_view | input | 2 | Write view: 00 word, 01 half, 10 low byte, 11 high byte |
| wr_data | input | 32 | Write data; a narrow view uses the low bits of this bus |
| wr_illegal | output | 1 | Write requested through a byte view that does not exist |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_view | input | 2 | Read port 0 view |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_illegal | output | 1 | Read port 0 byte view does not exist |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_view | input | 2 | Read port 1 view |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_illegal | output | 1 | Read port 1 byte view does not exist |

## Verification
Every register is first loaded with a distinct full-word pattern. After that, each narrow view is written with a second pattern whose bytes all differ from the first. Every index and view combination is then read back on both ports. Because the old and new bytes differ, a merge that overwrites a neighbouring field shows up, as does a mis-placed high byte or a missing zero-extension. Port 1 always reads a different index and view from port 0, which exposes cross-wired ports. Byte-view writes to the upper four registers, disabled writes, and a read-during-write of the same register check that state is kept where it must be.

// File: rtl/gpr_file_pkg.sv
`timescale 1ns/1ps
package gpr_file_pkg;
  typedef enum logic [1:0] {
    VIEW_WORD = 2'b00,
    VIEW_HALF = 2'b01,
    VIEW_LOB  = 2'b10,
    VIEW_HIB  = 2'b11
  } view_e;

  function automatic logic view_is_byte(input view_e v);
    return v[1];
  endfunction
endpackage

// File: rtl/rf_access_check.sv
`timescale 1ns/1ps
module rf_access_check #(
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]   idx,
  input  gpr_file_pkg::view_e view,
  output logic               no_view
);
  // byte views exist only for the low-numbered register group
  always_comb begin
    no_view = gpr_file_pkg::view_is_byte(view) && (32'(idx) >= BYTE_REGS);
  end
endmodule

// File: rtl/rf_write_merge.sv
`timescale 1ns/1ps
module rf_write_merge #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int BYTE_W = DATA_W / 4
) (
  input  logic [DATA_W-1:0]  cur_word,
  input  logic [DATA_W-1:0]  new_data,
  input  gpr_file_pkg::view_e view,
  output logic [DATA_W-1:0]  merged
);
  always_comb begin
    merged = cur_word;
    unique case (view)
      gpr_file_pkg::VIEW_WORD: merged = new_data;
      gpr_file_pkg::VIEW_HALF: merged[HALF_W-1:0] = new_data[HALF_W-1:0];
      gpr_file_pkg::VIEW_LOB:  merged[BYTE_W-1:0] = new_data[BYTE_W-1:0];
      gpr_file_pkg::VIEW_HIB:  merged[HALF_W-1:BYTE_W] = new_data[BYTE_W-1:0];
      default:                 merged = cur_word;
    endcase
  end
endmodule

// File: rtl/rf_read_extract.sv
`timescale 1ns/1ps
module rf_read_extract #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int BYTE_W = DATA_W / 4
) (
  input  logic [DATA_W-1:0]  word,
  input  gpr_file_pkg::view_e view,
  output logic [DATA_W-1:0]  field
);
  always_comb begin
    field = '0;
    unique case (view)
      gpr_file_pkg::VIEW_WORD: field = word;
      gpr_file_pkg::VIEW_HALF: field[HALF_W-1:0] = word[HALF_W-1:0];
      gpr_file_pkg::VIEW_LOB:  field[BYTE_W-1:0] = word[BYTE_W-1:0];
      gpr_file_pkg::VIEW_HIB:  field[BYTE_W-1:0] = word[HALF_W-1:BYTE_W];
      default:                 field = '0;
    endcase
  end
endmodule

// File: rtl/gpr_file.sv
`timescale 1ns/1ps
module gpr_file #(
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 32,
  parameter int BYTE_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int HALF_W   = DATA_W / 2,
  localparam int NUM_RD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_view,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_illegal,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_view,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_illegal,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_view,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_illegal
);
  import gpr_file_pkg::*;

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  // ---------------- write path ----------------
  view_e             wr_view_e;
  logic              wr_no_view;
  logic              wr_fire;
  logic [DATA_W-1:0] wr_cur;
  logic [DATA_W-1:0] wr_next;
  logic [NUM_REGS-1:0] reg_we;

  assign wr_view_e = view_e'(wr_view);

  rf_access_check #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_wr_chk (
    .idx     (wr_idx),
    .view    (wr_view_e),
    .no_view (wr_no_view)
  );

  always_comb begin
    wr_illegal = wr_en && wr_no_view;
    wr_fire    = wr_en && !wr_no_view;
    wr_cur     = regs_q[wr_idx];
  end

  rf_write_merge #(.DATA_W(DATA_W)) u_merge (
    .cur_word (wr_cur),
    .new_data (wr_data),
    .view     (wr_view_e),
    .merged   (wr_next)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_comb begin
      reg_we[i] = wr_fire && (32'(wr_idx) == i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (reg_we[i]) begin
        regs_q[i] <= wr_next;
      end
    end

    // R11 and R6: register untouched unless a legal enabled write targets it
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && (32'(wr_idx) == i)) || wr_illegal) |=> $stable(regs_q[i]));

    // R2: word write lands whole
    p_word_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (32'(wr_idx) == i) && (wr_view == 2'b00))
        |=> (regs_q[i] == $past(wr_data)));

    // R3: narrow write keeps the upper half
    p_upper_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (32'(wr_idx) == i) && (wr_view != 2'b00) && !wr_illegal)
        |=> (regs_q[i][DATA_W-1:HALF_W] == $past(regs_q[i][DATA_W-1:HALF_W])));
  end

  // ---------------- read path ----------------
  logic [IDX_W-1:0]  rd_idx  [NUM_RD];
  view_e             rd_view [NUM_RD];
  logic [DATA_W-1:0] rd_out  [NUM_RD];
  logic              rd_bad  [NUM_RD];

  assign rd_idx[0]  = rd0_idx;
  assign rd_idx[1]  = rd1_idx;
  assign rd_view[0] = view_e'(rd0_view);
  assign rd_view[1] = view_e'(rd1_view);

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [DATA_W-1:0] field;
    logic              no_view;

    rf_access_check #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_chk (
      .idx     (rd_idx[p]),
      .view    (rd_view[p]),
      .no_view (no_view)
    );

    rf_read_extract #(.DATA_W(DATA_W)) u_ext (
      .word  (regs_q[rd_idx[p]]),
      .view  (rd_view[p]),
      .field (field)
    );

    always_comb begin
      rd_bad[p] = no_view;
      rd_out[p] = no_view ? '0 : field;
    end

    // R7: narrow reads are zero-extended
    p_zero_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_view[p] != VIEW_WORD) |-> (rd_out[p][DATA_W-1:HALF_W] == '0));

    // R8: missing byte view reads as zero
    p_bad_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_bad[p] |-> (rd_out[p] == '0));
  end

  assign rd0_data    = rd_out[0];
  assign rd1_data    = rd_out[1];
  assign rd0_illegal = rd_bad[0];
  assign rd1_illegal = rd_bad[1];
endmodule

// File: tb/gpr_file_test.sv
`timescale 1ns/1ps
module gpr_file_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_view;
  logic [31:0] wr_data;
  logic        wr_illegal;
  logic [2:0]  rd0_idx, rd1_idx;
  logic [1:0]  rd0_view, rd1_view;
  logic [31:0] rd0_data, rd1_data;
  logic        rd0_illegal, rd1_illegal;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [8];

  always #2.5 clk = ~clk;

  gpr_file uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data),
    .wr_illegal(wr_illegal),
    .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
  );

  function automatic logic no_view(input logic [2:0] idx, input logic [1:0] v);
    return v[1] && (idx >= 3'd4);
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] idx, input logic [1:0] v);
    logic [31:0] w;
    w = model[idx];
    if (no_view(idx, v)) return 32'd0;
    case (v)
      2'b00:   return w;
      2'b01:   return w % 32'h10000;
      2'b10:   return w % 32'h100;
      default: return (w / 32'h100) % 32'h100;
    endcase
  endfunction

  function automatic logic [31:0] exp_write(input logic [31:0] old, input logic [1:0] v,
                                             input logic [31:0] d);
    case (v)
      2'b00:   return d;
      2'b01:   return (old & 32'hFFFF0000) | (d % 32'h10000);
      2'b10:   return (old & 32'hFFFFFF00) | (d % 32'h100);
      default: return (old & 32'hFFFF00FF) | ((d % 32'h100) * 32'h100);
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // read every index/view on port 0; port 1 reads a different index and view
  task automatic read_all(input string req);
    for (int i = 0; i < 8; i++) begin
      for (int v = 0; v < 4; v++) begin
        rd0_idx  = 3'(i);
        rd0_view = 2'(v);
        rd1_idx  = 3'(7 - i);
        rd1_view = 2'(3 - v);
        #1;
        chk({req, " R7 port0 data"}, rd0_data, exp_read(rd0_idx, rd0_view));
        chk({req, " R10 port1 data"}, rd1_data, exp_read(rd1_idx, rd1_view));
        chk({req, " R8 port0 flag"}, 32'(rd0_illegal), 32'(no_view(rd0_idx, rd0_view)));
        chk({req, " R8 port1 flag"}, 32'(rd1_illegal), 32'(no_view(rd1_idx, rd1_view)));
      end
    end
  endtask

  task automatic write_op(input logic [2:0] idx, input logic [1:0] v, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_view = v; wr_data = d;
    #1;
    chk("R6 wr_illegal", 32'(wr_illegal), 32'(no_view(idx, v)));
    @(negedge clk);
    wr_en = 1'b0;
    if (!no_view(idx, v)) model[idx] = exp_write(model[idx], v, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_view = '0; wr_data = '0;
    rd0_idx = '0; rd0_view = '0; rd1_idx = '0; rd1_view = '0;
    for (int i = 0; i < 8; i++) model[i] = 32'd0;
    repeat (3) @(negedge clk);
    read_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1 after reset");

    // R2: distinct word in each register
    for (int i = 0; i < 8; i++)
      write_op(3'(i), 2'b00, 32'hA1B2C3D4 ^ (32'(i) * 32'h11111111));
    read_all("R2 word writes");

    // R3: half writes
    for (int i = 0; i < 8; i++)
      write_op(3'(i), 2'b01, 32'h5E6F0000 | (32'h7080 + 32'(i)));
    read_all("R3 half writes");

    // R4: low byte writes (illegal on 4..7, R6)
    for (int i = 0; i < 8; i++)
      write_op(3'(i), 2'b10, 32'hFFFFFF00 | (32'h30 + 32'(i)));
    read_all("R4 low byte / R6");

    // R5: high byte writes (illegal on 4..7, R6)
    for (int i = 0; i < 8; i++)
      write_op(3'(i), 2'b11, 32'hEEEEEE00 | (32'h90 + 32'(i)));
    read_all("R5 high byte / R6");

    // R11: disabled write
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 3'd1; wr_view = 2'b00; wr_data = 32'hDEADBEEF;
    @(negedge clk);
    read_all("R11 wr_en low");
    chk("R11 wr_illegal low", 32'(wr_illegal), 32'd0);

    // R9: read during write of the same register
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd2; wr_view = 2'b00; wr_data = 32'h0BADF00D;
    rd0_idx = 3'd2; rd0_view = 2'b00;
    #1;
    chk("R9 old value same cycle", rd0_data, model[2]);
    @(negedge clk);
    wr_en = 1'b0;
    model[2] = 32'h0BADF00D;
    #1;
    chk("R9 new value next cycle", rd0_data, 32'h0BADF00D);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 32'd0;
    #1;
    read_all("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule